// File: doc/BRIEF.md
# Pointer-indexed register slave port

This block is the host-facing slave side of a peripheral. It holds a small pointer register and four 16-bit control/status registers. The host reaches all of them over one shared 16-bit data bus. A single address line picks between the pointer and the register that the pointer currently names. A cycle begins when chip select and the data strobe are both active. The port then performs exactly one read or write and answers with a ready signal, which it holds until the host ends the cycle.

Register 0 carries a stop bit at bit position 2. While that bit is clear, the device counts as running, and registers 1 to 3 are locked: writes to them are dropped and reads of them return zero. Ready still completes such a cycle, so the host never stalls.

Any write to register 0 with the stop bit set schedules a device reset. The reset waits until the current slave cycle has ended. It then takes one clock, during which every output enable is withdrawn so the bus pins float. At the end of that clock, register 0 holds only the stop bit. Registers 1 to 3 and the pointer keep their contents.

Top module: `regport_slave`

## Requirements
- R1: After reset, rdy_o, rdy_oe_o and bus_oe_o are low, and the pointer and all four registers read as zero.
- R2: With adr_i = 1 the cycle reaches the pointer. A write keeps only bits 1:0, and a read returns those two bits with bits 15:2 equal to zero.
- R3: With adr_i = 0 the cycle reaches the register whose number the pointer holds. A write stores all 16 bits of bus_i, and a later read returns them.
- R4: The pointer and register 0 can be read and written whether or not the stop bit (register 0 bit 2) is set.
- R5: While the stop bit is clear, a write to register 1, 2 or 3 leaves that register unchanged, and a read of it returns 0x0000, yet rdy_o is still asserted.
- R6: Once cs_i and strb_i are both sampled high in the idle state, rdy_o rises at the next clock edge. For a read (rd_i = 1), bus_o holds the selected value from that edge, and bus_oe_o is high while cs_i and rd_i are high.
- R7: A write (rd_i = 0) stores its data at the first clock edge of the cycle and leaves bus_oe_o low.
- R8: rdy_o falls at the first clock edge at which cs_i or strb_i is sampled low.
- R9: rdy_oe_o follows cs_i, except during the reset clock of R10.
- R10: A write of register 0 with bit 2 set starts no reset until the cycle ends. The clock after the cycle ends is a reset clock: rdy_oe_o and bus_oe_o are low, and no new cycle starts. After it, register 0 reads 0x0004.
- R11: While cs_i and strb_i stay high, rdy_o stays high and no second access is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| strb_i | input | 1 | Data strobe, active high |
| rd_i | input | 1 | 1 = read cycle, 0 = write cycle |
| adr_i | input | 1 | 1 = pointer, 0 = register named by the pointer |
| bus_i | input | 16 | Write data from the shared bus |
| bus_o | output | 16 | Read data to the shared bus |
| bus_oe_o | output | 1 | Drive enable for bus_o |
| rdy_o | output | 1 | Ready handshake |
| rdy_oe_o | output | 1 | Drive enable for ready; low means floating |

## Verification
The timing of each result, counted from the edge that first samples cs_i and strb_i high:
- rdy_o and the read data appear one edge later.
- A write is visible to the next read cycle.
- rdy_o falls one edge after the release is sampled.
- When a stop write was made, the reset clock follows that edge, and register 0 holds its reset value one edge later still.

The bench drives every input on the falling edge and reads every output on the next falling edge. Each check therefore falls exactly half a clock after the rising edge that produced the result. The float check during the reset clock is read one time unit after the inputs change, because the output enables are combinational.

// File: rtl/regport_pkg.sv
package regport_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_DONE  = 2'd1,
    CYC_FLUSH = 2'd2
  } cyc_state_e;
endpackage

// File: rtl/regport_cycle.sv
module regport_cycle
  import regport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic pend_i,
  output logic go_o,
  output logic rdy_o,
  output logic flush_o
);
  cyc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      CYC_IDLE:  if (act_i) state_d = CYC_DONE;
      CYC_DONE:  if (!act_i) state_d = pend_i ? CYC_FLUSH : CYC_IDLE;
      CYC_FLUSH: state_d = CYC_IDLE;
      default:   state_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CYC_IDLE;
    else        state_q <= state_d;
  end

  assign go_o    = (state_q == CYC_IDLE) && act_i;
  assign rdy_o   = (state_q == CYC_DONE);
  assign flush_o = (state_q == CYC_FLUSH);

  // R6: ready follows the access edge
  p_rdy_after_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |=> rdy_o);
  // R8: ready drops once the cycle is released
  p_rdy_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !act_i) |=> !rdy_o);
  // R10: the reset clock lasts one cycle and never carries ready
  p_flush_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> (!flush_o && !rdy_o));
  // R11: a held cycle keeps ready and starts no new access
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && act_i) |=> (rdy_o && !go_o));
endmodule

// File: rtl/regport_file.sv
module regport_file #(
  parameter int DW       = 16,
  parameter int NREG     = 4,
  parameter int STOP_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          flush_i,
  input  logic          adr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          pend_o
);
  localparam int PW = $clog2(NREG);
  localparam logic [DW-1:0] STOP_MASK = {{(DW-1){1'b0}}, 1'b1} << STOP_BIT;

  logic [PW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];
  logic [DW-1:0] rdata_q, rdata_d;
  logic          pend_q, pend_d;
  logic          stopped, open_sel;

  assign stopped  = regs_q[0][STOP_BIT];
  assign open_sel = (ptr_q == '0) || stopped;

  always_comb begin
    ptr_d   = ptr_q;
    rdata_d = rdata_q;
    pend_d  = pend_q;
    for (int i = 0; i < NREG; i++) regs_d[i] = regs_q[i];
    if (go_i && rd_i) begin
      if (adr_i)         rdata_d = {{(DW-PW){1'b0}}, ptr_q};
      else if (open_sel) rdata_d = regs_q[ptr_q];
      else               rdata_d = '0;
    end
    if (go_i && !rd_i) begin
      if (adr_i) begin
        ptr_d = wdata_i[PW-1:0];
      end else if (open_sel) begin
        regs_d[ptr_q] = wdata_i;
        if ((ptr_q == '0) && wdata_i[STOP_BIT]) pend_d = 1'b1;
      end
    end
    if (flush_i) begin
      regs_d[0] = STOP_MASK;
      pend_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rdata_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      rdata_q <= rdata_d;
      pend_q  <= pend_d;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[k] <= '0;
      else        regs_q[k] <= regs_d[k];
    end
    if (k > 0) begin : g_lock
      // R5: locked registers keep their value while running
      p_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !rd_i && !adr_i && (ptr_q == PW'(k)) && !stopped)
        |=> (regs_q[k] == $past(regs_q[k])));
    end
  end

  assign rdata_o = rdata_q;
  assign pend_o  = pend_q;

  // R2: pointer readback has zero upper bits
  p_ptr_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && rd_i && adr_i) |=> (rdata_o[DW-1:PW] == '0));
  // R5: locked reads return zero
  p_locked_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && rd_i && !adr_i && (ptr_q != '0) && !stopped) |=> (rdata_o == '0));
  // R10: the reset clock leaves only the stop bit set and clears the request
  p_flush_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> ((regs_q[0] == STOP_MASK) && !pend_o));
endmodule

// File: rtl/regport_slave.sv
module regport_slave #(
  parameter int DW       = 16,
  parameter int NREG     = 4,
  parameter int STOP_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          strb_i,
  input  logic          rd_i,
  input  logic          adr_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic          rdy_o,
  output logic          rdy_oe_o
);
  logic act, go, flush, pend;

  assign act = cs_i && strb_i;

  regport_cycle u_cycle (
    .clk     (clk),
    .rst_n   (rst_n),
    .act_i   (act),
    .pend_i  (pend),
    .go_o    (go),
    .rdy_o   (rdy_o),
    .flush_o (flush)
  );

  regport_file #(.DW(DW), .NREG(NREG), .STOP_BIT(STOP_BIT)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (go),
    .flush_i (flush),
    .adr_i   (adr_i),
    .rd_i    (rd_i),
    .wdata_i (bus_i),
    .rdata_o (bus_o),
    .pend_o  (pend)
  );

  assign bus_oe_o = cs_i && rd_i && !flush;
  assign rdy_oe_o = cs_i && !flush;

  // R10: a pending reset never cuts short a cycle that is still held
  p_defer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && act) |=> !flush);
endmodule

// File: tb/sim_regport_slave.sv
module sim_regport_slave;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_i, strb_i, rd_i, adr_i;
  logic [15:0] bus_i;
  logic [15:0] bus_o;
  logic        bus_oe_o, rdy_o, rdy_oe_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] m_reg [4];
  logic [1:0]  m_ptr;
  bit          m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  regport_slave u0 (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .strb_i(strb_i), .rd_i(rd_i),
    .adr_i(adr_i), .bus_i(bus_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o),
    .rdy_o(rdy_o), .rdy_oe_o(rdy_oe_o)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic a);
    if (a) return {14'b0, m_ptr};
    if (m_ptr == 2'd0 || m_reg[0][2]) return m_reg[m_ptr];
    return 16'h0000;
  endfunction

  function automatic void exp_write(input logic a, input logic [15:0] w);
    if (a) m_ptr = w[1:0];
    else if (m_ptr == 2'd0) begin
      m_reg[0] = w;
      if (w[2]) m_pend = 1'b1;
    end else if (m_reg[0][2]) m_reg[m_ptr] = w;
  endfunction

  // one slave cycle, starting and ending on a falling edge
  task automatic do_cycle(input logic a, input logic r, input logic [15:0] w,
                          input int hold, input int rel);
    logic [15:0] e;
    e = exp_read(a);
    cs_i = 1'b1; strb_i = 1'b1; rd_i = r; adr_i = a; bus_i = w;
    if (!r) exp_write(a, w);
    @(negedge clk);
    chk(rdy_o == 1'b1, "R6 ready rise", 16'(rdy_o), 16'h1);
    chk(rdy_oe_o == 1'b1, "R9 ready enable", 16'(rdy_oe_o), 16'h1);
    if (r) begin
      chk(bus_oe_o == 1'b1, "R6 read drive", 16'(bus_oe_o), 16'h1);
      chk(bus_o == e, a ? "R2 pointer read" : (m_ptr == 0 ? "R4 reg0 read" :
          (m_reg[0][2] ? "R3 indexed read" : "R5 locked read")), bus_o, e);
    end else begin
      chk(bus_oe_o == 1'b0, "R7 write no drive", 16'(bus_oe_o), 16'h0);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rdy_o == 1'b1, "R11 ready held", 16'(rdy_o), 16'h1);
    end
    if (rel == 0) cs_i = 1'b0;
    else if (rel == 1) strb_i = 1'b0;
    else begin cs_i = 1'b0; strb_i = 1'b0; end
    @(negedge clk);
    chk(rdy_o == 1'b0, "R8 ready release", 16'(rdy_o), 16'h0);
    chk(rdy_oe_o == (cs_i && !m_pend), m_pend ? "R10 float" : "R9 ready enable",
        16'(rdy_oe_o), 16'(cs_i && !m_pend));
    if (m_pend) begin
      @(negedge clk);
      m_reg[0] = 16'h0004;
      m_pend = 1'b0;
    end
    cs_i = 1'b0; strb_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) m_reg[i] = 16'h0;
    m_ptr = 2'd0; m_pend = 1'b0;
    rst_n = 1'b0; cs_i = 0; strb_i = 0; rd_i = 0; adr_i = 0; bus_i = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_o == 1'b0, "R1 reset ready", 16'(rdy_o), 16'h0);
    chk(rdy_oe_o == 1'b0, "R1 reset ready enable", 16'(rdy_oe_o), 16'h0);
    chk(bus_oe_o == 1'b0, "R1 reset bus enable", 16'(bus_oe_o), 16'h0);
    do_cycle(1'b0, 1'b1, 16'h0, 0, 2);   // R1 reg0 reads zero
    do_cycle(1'b1, 1'b1, 16'h0, 0, 2);   // R1 pointer reads zero
    do_cycle(1'b1, 1'b0, 16'hFFFF, 0, 2); // R2 pointer keeps two bits
    do_cycle(1'b1, 1'b1, 16'h0, 1, 0);
    do_cycle(1'b0, 1'b0, 16'hBEEF, 0, 1); // R5 locked write to reg3
    do_cycle(1'b0, 1'b1, 16'h0, 0, 2);    // R5 locked read
    do_cycle(1'b1, 1'b0, 16'h0000, 0, 2);
    do_cycle(1'b0, 1'b0, 16'h0004, 0, 2); // R10 stop write with reset
    do_cycle(1'b1, 1'b0, 16'h0003, 0, 2);
    do_cycle(1'b0, 1'b1, 16'h0, 0, 2);    // R5 reg3 still zero
    do_cycle(1'b0, 1'b0, 16'h1234, 0, 2); // R3 indexed write
    do_cycle(1'b0, 1'b1, 16'h0, 2, 1);    // R3 and R11
    // R10 directed: reset clock floats outputs and blocks a new cycle
    do_cycle(1'b1, 1'b0, 16'h0000, 0, 2);
    cs_i = 1; strb_i = 1; rd_i = 0; adr_i = 0; bus_i = 16'h0014;
    @(negedge clk);
    cs_i = 0; strb_i = 0;
    @(negedge clk);
    cs_i = 1; strb_i = 1; rd_i = 1; adr_i = 0;
    #1;
    chk(rdy_oe_o == 1'b0, "R10 ready floats", 16'(rdy_oe_o), 16'h0);
    chk(bus_oe_o == 1'b0, "R10 bus floats", 16'(bus_oe_o), 16'h0);
    @(negedge clk);
    chk(rdy_o == 1'b0, "R10 no cycle in reset clock", 16'(rdy_o), 16'h0);
    @(negedge clk);
    chk(rdy_o == 1'b1, "R10 cycle after reset", 16'(rdy_o), 16'h1);
    chk(bus_o == 16'h0004, "R10 reg0 after reset", bus_o, 16'h0004);
    cs_i = 0; strb_i = 0;
    @(negedge clk);
    m_reg[0] = 16'h0004;
    // R4: reg0 written back to running, still reachable
    do_cycle(1'b0, 1'b0, 16'h0A30, 0, 2);
    do_cycle(1'b0, 1'b1, 16'h0, 0, 0);
    for (int t = 0; t < 600; t++) begin
      logic a, r;
      logic [15:0] w;
      a = 1'($urandom % 3 == 0);
      r = 1'($urandom % 2);
      w = 16'($urandom);
      do_cycle(a, r, w, int'($urandom % 3), int'($urandom % 3));
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule